// File: doc/BRIEF.md
# Receive TLP Steering Unit with Address-Window Check

This unit sits between the transaction layer of a PCI Express core and the user logic, on the receive side. Packets arrive as a beat stream with valid/ready handshaking and start/end markers, and the full TLP header is in the low 128 bits of the first beat. The unit reads the format and type fields of that first beat and decides where the whole packet goes. Configuration requests go to a local configuration-handler port. Everything else goes to the application port, bit for bit.

Memory requests are also checked against a small set of programmable address windows. Each window has a base, a compare mask and an enable. A memory read that lands in no enabled window does not go to the application. Instead, the unit builds an Unsupported Request completion header and places it on a separate output, where the transmit merger picks it up. A memory write that misses is posted, so it gets no reply and is discarded.

The unit keeps no table of outstanding requests. Completions arriving from the link go to the application in arrival order, whatever their tag.

Top module: `tlp_rx_steer`

## Requirements
- R1: A packet whose first-beat type field (bits 28:24) is 5'b00100 or 5'b00101 goes out on the configuration port, with any format value (bits 31:29), and never on the application port.
- R2: Every packet not covered by R1, R6 or R8 goes out on the application port, with data, start and end markers unchanged, in the same cycle it is presented.
- R3: Packets leave each port in the order they were accepted, and a beat is never reordered or dropped.
- R4: Completions (type 5'b01010) with any tag are forwarded even when no matching request was seen. The unit never filters completions or generates one for them.
- R5: A memory read is type 5'b00000 with format 3'b000 or 3'b001. A memory write is type 5'b00000 with format 3'b010 or 3'b011. For a 3-DW header (format bit 0 clear), the address is bits 95:66 as address bits 31:2, with the upper half zero. For a 4-DW header, address bits 63:32 are bits 95:64 and address bits 31:2 are bits 127:98. Window i hits when its enable is set and (addr & mask) equals (base & mask). A memory request that hits any enabled window goes to the application port.
- R6: A memory read that hits no enabled window produces no beat on the application or configuration port. The unit presents a completion on the completion port from the clock edge that accepts the read.
- R7: The completion header has these fields: format 3'b000 and type 5'b01010 in bits 31:24, length 0 in bits 9:0, completer ID in bits 63:48, status 3'b001 in bits 47:45, byte count 0 in bits 43:32, the request's requester ID (its bits 63:48) in bits 95:80, and the request's tag (its bits 47:40) in bits 79:72. All other bits are zero.
- R8: A memory write that hits no enabled window is accepted at once (ready high) and appears on no output.
- R9: While the port selected for the current beat has ready low, input ready is low and the beat stays presented unchanged on that port.
- R10: The destination chosen on a packet's first beat holds for every later beat of that packet, whatever those beats contain.
- R11: While a completion is held on the completion port and that port's ready is low, a further window-miss read is stalled (input ready low) and the held completion stays unchanged.
- R12: During and right after reset, no output port asserts valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DATA_W | Input beat; header in bits 127:0 of the first beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| cfg_valid | output | 1 | Configuration port beat valid |
| cfg_ready | input | 1 | Configuration port ready |
| cfg_data | output | DATA_W | Configuration port beat |
| cfg_sop | output | 1 | Configuration port first beat |
| cfg_eop | output | 1 | Configuration port last beat |
| app_valid | output | 1 | Application port beat valid |
| app_ready | input | 1 | Application port ready |
| app_data | output | DATA_W | Application port beat |
| app_sop | output | 1 | Application port first beat |
| app_eop | output | 1 | Application port last beat |
| cpl_valid | output | 1 | Generated completion valid |
| cpl_ready | input | 1 | Generated completion taken |
| cpl_data | output | 128 | Generated completion header (single beat) |
| completer_id | input | 16 | ID placed in generated completions |
| bar_base | input | NUM_BARS*64 | Window base addresses, window i at bits 64*i+63:64*i |
| bar_mask | input | NUM_BARS*64 | Window compare masks, same packing |
| bar_en | input | NUM_BARS | Window enables |

## Verification
The hardest case to reach from the ports is a second window-miss read that arrives while the single completion slot is still full and the transmit side is holding it off. The stimulus holds cpl_ready low, sends one miss read, then presents a second one. It checks that input ready stays low and the first header stays frozen, then releases ready and checks that the second header replaces the first one edge later. A route-holding case is also forced on purpose: continuation beats are filled with bit patterns that would decode as a configuration request or a miss read, and the port is back-pressured in the middle of the packet.

// File: rtl/tlp_rx_steer_pkg.sv
package tlp_rx_steer_pkg;
    localparam int HDR_W  = 128;
    localparam int ADDR_W = 64;

    localparam logic [4:0] TY_MEM  = 5'b00000;
    localparam logic [4:0] TY_CFG0 = 5'b00100;
    localparam logic [4:0] TY_CFG1 = 5'b00101;
    localparam logic [4:0] TY_CPL  = 5'b01010;
    localparam logic [2:0] ST_UR   = 3'b001;

    typedef enum logic [1:0] {
        DST_APP  = 2'd0,
        DST_CFG  = 2'd1,
        DST_DROP = 2'd2,
        DST_UR   = 2'd3
    } dest_e;

    typedef struct packed {
        dest_e dest;
        logic  in_pkt;
    } steer_st_t;

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        logic             vld;
    } cpl_st_t;
endpackage

// File: rtl/rxs_hdr_decode.sv
module rxs_hdr_decode
    import tlp_rx_steer_pkg::*;
(
    input  logic [HDR_W-1:0]  hdr,
    output logic              is_cfg,
    output logic              is_mrd,
    output logic              is_mwr,
    output logic [ADDR_W-1:0] addr,
    output logic [15:0]       req_id,
    output logic [7:0]        tag
);
    logic [2:0] fmt;
    logic [4:0] typ;
    logic       unused_hdr;

    always_comb begin
        fmt    = hdr[31:29];
        typ    = hdr[28:24];
        is_cfg = (typ == TY_CFG0) || (typ == TY_CFG1);
        is_mrd = (typ == TY_MEM) && (fmt[2:1] == 2'b00);
        is_mwr = (typ == TY_MEM) && (fmt[2:1] == 2'b01);
        if (fmt[0]) begin
            addr = {hdr[95:64], hdr[127:98], 2'b00};
        end else begin
            addr = {32'h0, hdr[95:66], 2'b00};
        end
        req_id = hdr[63:48];
        tag    = hdr[47:40];
    end

    assign unused_hdr = ^{hdr[23:0], hdr[39:32], hdr[97:96]};
endmodule

// File: rtl/rxs_bar_match.sv
module rxs_bar_match
    import tlp_rx_steer_pkg::*;
#(
    parameter int NUM_BARS = 2
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_BARS*ADDR_W-1:0] bar_base,
    input  logic [NUM_BARS*ADDR_W-1:0] bar_mask,
    input  logic [NUM_BARS-1:0]        bar_en,
    output logic                       hit
);
    logic [NUM_BARS-1:0] win_hit;

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_win
        logic [ADDR_W-1:0] base_i;
        logic [ADDR_W-1:0] mask_i;
        assign base_i     = bar_base[i*ADDR_W +: ADDR_W];
        assign mask_i     = bar_mask[i*ADDR_W +: ADDR_W];
        assign win_hit[i] = bar_en[i] && ((addr & mask_i) == (base_i & mask_i));
    end

    assign hit = |win_hit;
endmodule

// File: rtl/rxs_ur_gen.sv
module rxs_ur_gen
    import tlp_rx_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [15:0]      req_id,
    input  logic [7:0]       tag,
    input  logic [15:0]      cpl_id,
    output logic             slot_free,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [HDR_W-1:0] out_data
);
    cpl_st_t st_d, st_q;

    assign slot_free = !st_q.vld || out_ready;
    assign out_valid = st_q.vld;
    assign out_data  = st_q.hdr;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.vld           = 1'b1;
            st_d.hdr           = '0;
            st_d.hdr[31:29]    = 3'b000;
            st_d.hdr[28:24]    = TY_CPL;
            st_d.hdr[63:48]    = cpl_id;
            st_d.hdr[47:45]    = ST_UR;
            st_d.hdr[95:80]    = req_id;
            st_d.hdr[79:72]    = tag;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: a held completion stays put while the transmit side stalls
    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R11: a new completion is only loaded into a free slot
    a_r11_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> slot_free);

    // R6: a loaded completion is presented from the next edge
    a_r6_load_shows: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_valid);
endmodule

// File: rtl/tlp_rx_steer.sv
module tlp_rx_steer
    import tlp_rx_steer_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int NUM_BARS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [DATA_W-1:0]          in_data,
    input  logic                       in_sop,
    input  logic                       in_eop,
    output logic                       cfg_valid,
    input  logic                       cfg_ready,
    output logic [DATA_W-1:0]          cfg_data,
    output logic                       cfg_sop,
    output logic                       cfg_eop,
    output logic                       app_valid,
    input  logic                       app_ready,
    output logic [DATA_W-1:0]          app_data,
    output logic                       app_sop,
    output logic                       app_eop,
    output logic                       cpl_valid,
    input  logic                       cpl_ready,
    output logic [HDR_W-1:0]           cpl_data,
    input  logic [15:0]                completer_id,
    input  logic [NUM_BARS*ADDR_W-1:0] bar_base,
    input  logic [NUM_BARS*ADDR_W-1:0] bar_mask,
    input  logic [NUM_BARS-1:0]        bar_en
);
    logic              is_cfg, is_mrd, is_mwr, bar_hit, slot_free, ur_load, fire;
    logic [ADDR_W-1:0] req_addr;
    logic [15:0]       req_id;
    logic [7:0]        req_tag;
    dest_e             new_dest, cur_dest;
    steer_st_t         st_d, st_q;

    rxs_hdr_decode u_dec (
        .hdr    (in_data[HDR_W-1:0]),
        .is_cfg (is_cfg),
        .is_mrd (is_mrd),
        .is_mwr (is_mwr),
        .addr   (req_addr),
        .req_id (req_id),
        .tag    (req_tag)
    );

    rxs_bar_match #(.NUM_BARS(NUM_BARS)) u_bar (
        .addr     (req_addr),
        .bar_base (bar_base),
        .bar_mask (bar_mask),
        .bar_en   (bar_en),
        .hit      (bar_hit)
    );

    rxs_ur_gen u_ur (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ur_load),
        .req_id    (req_id),
        .tag       (req_tag),
        .cpl_id    (completer_id),
        .slot_free (slot_free),
        .out_valid (cpl_valid),
        .out_ready (cpl_ready),
        .out_data  (cpl_data)
    );

    always_comb begin
        if (is_cfg) begin
            new_dest = DST_CFG;
        end else if (is_mrd && !bar_hit) begin
            new_dest = DST_UR;
        end else if (is_mwr && !bar_hit) begin
            new_dest = DST_DROP;
        end else begin
            new_dest = DST_APP;
        end
        cur_dest = in_sop ? new_dest : st_q.dest;

        case (cur_dest)
            DST_CFG:  in_ready = cfg_ready;
            DST_DROP: in_ready = 1'b1;
            DST_UR:   in_ready = in_sop ? slot_free : 1'b1;
            default:  in_ready = app_ready;
        endcase

        cfg_valid = in_valid && (cur_dest == DST_CFG);
        app_valid = in_valid && (cur_dest == DST_APP);
        ur_load   = in_valid && in_sop && (cur_dest == DST_UR) && slot_free;
        fire      = in_valid && in_ready;

        st_d = st_q;
        if (fire) begin
            st_d.dest   = cur_dest;
            st_d.in_pkt = !in_eop;
        end
    end

    assign cfg_data = in_data;
    assign cfg_sop  = in_sop;
    assign cfg_eop  = in_eop;
    assign app_data = in_data;
    assign app_sop  = in_sop;
    assign app_eop  = in_eop;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{dest: DST_APP, in_pkt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R1: a beat never appears on both forwarding ports at once
    a_r1_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_valid, app_valid}));

    // R9: a stalled application port holds the input
    a_r9_app_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (app_valid && !app_ready) |-> !in_ready);

    // R9: a stalled configuration port holds the input
    a_r9_cfg_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |-> !in_ready);

    // R10: inside a packet the stored destination does not move
    a_r10_route_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_pkt && !(fire && in_eop) && !in_sop) |=> $stable(st_q.dest));

    // R8: a discarded write is accepted and shows on no port
    a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && is_mwr && !bar_hit) |-> (in_ready && !app_valid && !cfg_valid && !ur_load));

    // R6: a miss read never leaks to the application
    a_r6_no_app_leak: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && is_mrd && !bar_hit) |-> !app_valid);
endmodule

// File: tb/sim_tlp_rx_steer.sv
module sim_tlp_rx_steer;
    localparam int DW = 128;
    localparam int NB = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DW-1:0]  in_data = '0;
    logic           in_ready;
    logic           cfg_valid, cfg_sop, cfg_eop, app_valid, app_sop, app_eop, cpl_valid;
    logic [DW-1:0]  cfg_data, app_data;
    logic [127:0]   cpl_data;
    logic           cfg_ready = 1'b1, app_ready = 1'b1, cpl_ready = 1'b1;
    logic [15:0]    completer_id = 16'hBEEF;
    logic [NB*64-1:0] bar_base, bar_mask;
    logic [NB-1:0]  bar_en = 2'b11;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [63:0] B0 = 64'h0000_0000_8000_0000;
    localparam logic [63:0] M0 = 64'hFFFF_FFFF_FFF0_0000;
    localparam logic [63:0] B1 = 64'h0000_0012_3400_0000;
    localparam logic [63:0] M1 = 64'hFFFF_FFFF_FF00_0000;

    assign bar_base = {B1, B0};
    assign bar_mask = {M1, M0};

    tlp_rx_steer #(.DATA_W(DW), .NUM_BARS(NB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
        .cfg_sop(cfg_sop), .cfg_eop(cfg_eop),
        .app_valid(app_valid), .app_ready(app_ready), .app_data(app_data),
        .app_sop(app_sop), .app_eop(app_eop),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_data(cpl_data),
        .completer_id(completer_id),
        .bar_base(bar_base), .bar_mask(bar_mask), .bar_en(bar_en)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input logic [2:0] fmt, input logic [4:0] typ,
                                        input logic [63:0] a, input logic [15:0] rid, input logic [7:0] tg);
        logic [127:0] h = '0;
        h[31:29] = fmt;
        h[28:24] = typ;
        h[9:0]   = 10'd1;
        h[63:48] = rid;
        h[47:40] = tg;
        if (fmt[0]) begin
            h[95:64]  = a[63:32];
            h[127:96] = {a[31:2], 2'b00};
        end else begin
            h[95:64]  = {a[31:2], 2'b00};
        end
        return h;
    endfunction

    function automatic bit win_hit(input logic [63:0] a, input logic [1:0] en);
        return (en[0] && ((a & M0) == (B0 & M0))) || (en[1] && ((a & M1) == (B1 & M1)));
    endfunction

    // 0 app, 1 cfg, 2 drop, 3 completion generated
    function automatic int exp_dest(input logic [2:0] fmt, input logic [4:0] typ, input bit hit);
        if (typ == 5'b00100 || typ == 5'b00101) return 1;
        if (typ == 5'b00000 && fmt[2:1] == 2'b00 && !hit) return 3;
        if (typ == 5'b00000 && fmt[2:1] == 2'b01 && !hit) return 2;
        return 0;
    endfunction

    function automatic logic [127:0] exp_ur(input logic [15:0] rid, input logic [7:0] tg);
        logic [127:0] u = '0;
        u[28:24] = 5'b01010;
        u[63:48] = 16'hBEEF;
        u[47:45] = 3'b001;
        u[95:80] = rid;
        u[79:72] = tg;
        return u;
    endfunction

    task automatic push(input logic [127:0] d, input int dst, input logic [127:0] ucpl, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = 1'b1; in_eop = 1'b1;
        #1;
        case (dst)
            0: begin
                chk(app_valid && !cfg_valid, req, {app_valid, cfg_valid}, 2'b10);
                chk(app_data == d && app_sop && app_eop, req, app_data, d);
            end
            1: begin
                chk(cfg_valid && !app_valid, req, {cfg_valid, app_valid}, 2'b10);
                chk(cfg_data == d && cfg_sop && cfg_eop, req, cfg_data, d);
            end
            2: chk(in_ready && !app_valid && !cfg_valid, req, {in_ready, app_valid, cfg_valid}, 3'b100);
            default: chk(!app_valid && !cfg_valid, req, {app_valid, cfg_valid}, 2'b00);
        endcase
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        #1;
        if (dst == 3) chk(cpl_valid && cpl_data == ucpl, req, cpl_data, ucpl);
        else          chk(!cpl_valid, req, {127'b0, cpl_valid}, 128'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] addrs [8];
        logic [127:0] h, w, ha, hb;

        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(!app_valid && !cfg_valid && !cpl_valid, "R12 reset", {app_valid, cfg_valid, cpl_valid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!app_valid && !cfg_valid && !cpl_valid, "R12 after reset", {app_valid, cfg_valid, cpl_valid}, 3'b000);

        // R1 / R2: full format x type sweep with a hitting address
        for (int f = 0; f < 8; f++) begin
            for (int t = 0; t < 32; t++) begin
                h = mk(f[2:0], t[4:0], B0 + 64'h40, 16'(f * 32 + t), 8'(t));
                push(h, exp_dest(f[2:0], t[4:0], 1'b1), '0,
                     (t == 4 || t == 5) ? "R1 cfg sweep" : "R2 pass sweep");
            end
        end

        // R5 / R6 / R7 / R8: window sweep with every enable combination
        addrs[0] = 64'h0000_0000_8000_0000;
        addrs[1] = 64'h0000_0000_800F_FFFC;
        addrs[2] = 64'h0000_0000_7FFF_FFFC;
        addrs[3] = 64'h0000_0000_8010_0000;
        addrs[4] = 64'h0000_0012_3400_0000;
        addrs[5] = 64'h0000_0012_34FF_FFFC;
        addrs[6] = 64'h0000_0012_3500_0000;
        addrs[7] = 64'h0000_0000_0000_1000;
        for (int e = 0; e < 4; e++) begin
            bar_en = e[1:0];
            for (int k = 0; k < 8; k++) begin
                logic hit;
                logic [2:0] fr, fw;
                hit = win_hit(addrs[k], e[1:0]);
                fr = (addrs[k][63:32] != 0) ? 3'b001 : 3'b000;
                fw = (addrs[k][63:32] != 0) ? 3'b011 : 3'b010;
                h = mk(fr, 5'b00000, addrs[k], 16'(16'h1000 + e * 8 + k), 8'(8'hA0 + k));
                push(h, hit ? 0 : 3, exp_ur(16'(16'h1000 + e * 8 + k), 8'(8'hA0 + k)),
                     hit ? "R5 read hit" : "R6 R7 read miss");
                h = mk(fw, 5'b00000, addrs[k], 16'h2000, 8'(k));
                push(h, hit ? 0 : 2, '0, hit ? "R5 write hit" : "R8 write miss");
            end
        end
        bar_en = 2'b11;

        // R3 / R4: unsolicited completions, out-of-order tags, in arrival order
        push(mk(3'b000, 5'b01010, 64'h0, 16'h0007, 8'h03), 0, '0, "R4 R3 cpl tag 3");
        push(mk(3'b010, 5'b01010, 64'h0, 16'h0007, 8'h01), 0, '0, "R4 R3 cpl tag 1");
        push(mk(3'b000, 5'b01010, 64'h0, 16'h0007, 8'h02), 0, '0, "R4 R3 cpl tag 2");

        // R9 / R10: multi-beat write to application, stalls, cfg-looking payload
        h = mk(3'b010, 5'b00000, B0 + 64'h80, 16'h0102, 8'h11);
        @(negedge clk);
        app_ready = 1'b0;
        in_valid = 1'b1; in_data = h; in_sop = 1'b1; in_eop = 1'b0;
        #1;
        chk(app_valid && !in_ready, "R9 app stall", {app_valid, in_ready}, 2'b10);
        @(negedge clk);
        #1;
        chk(app_valid && app_data == h && !in_ready, "R9 beat held", app_data, h);
        app_ready = 1'b1;
        #1;
        chk(in_ready, "R9 release", {127'b0, in_ready}, 128'b1);
        @(posedge clk);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            w = mk(3'b000, 5'b00100, 64'h0, 16'(k), 8'(k));
            in_data = w; in_sop = 1'b0; in_eop = (k == 3);
            app_ready = (k != 2);
            #1;
            chk(app_valid && !cfg_valid && app_data == w && app_eop == (k == 3), "R10 app continuation", app_data, w);
            if (!app_ready) begin
                chk(!in_ready, "R9 mid-packet stall", {127'b0, in_ready}, 128'b0);
                @(negedge clk);
                app_ready = 1'b1;
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;

        // R9 / R10: two-beat cfg write whose payload looks like a miss read
        h = mk(3'b010, 5'b00100, 64'h0, 16'h0200, 8'h22);
        w = mk(3'b000, 5'b00000, 64'h0000_1000, 16'h0300, 8'h33);
        @(negedge clk);
        cfg_ready = 1'b0;
        in_valid = 1'b1; in_data = h; in_sop = 1'b1; in_eop = 1'b0;
        #1;
        chk(cfg_valid && !in_ready, "R9 cfg stall", {cfg_valid, in_ready}, 2'b10);
        @(negedge clk);
        cfg_ready = 1'b1;
        #1;
        @(posedge clk);
        @(negedge clk);
        in_data = w; in_sop = 1'b0; in_eop = 1'b1;
        #1;
        chk(cfg_valid && !app_valid && cfg_data == w, "R10 cfg continuation", cfg_data, w);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        #1;
        chk(!cpl_valid, "R10 no completion from payload", {127'b0, cpl_valid}, 128'b0);

        // R11: completion slot full while the transmit side stalls
        cpl_ready = 1'b0;
        ha = mk(3'b000, 5'b00000, 64'h0000_4000, 16'h0A0A, 8'h5A);
        hb = mk(3'b000, 5'b00000, 64'h0000_5000, 16'h0B0B, 8'h5B);
        push(ha, 3, exp_ur(16'h0A0A, 8'h5A), "R6 first miss read");
        @(negedge clk);
        in_valid = 1'b1; in_data = hb; in_sop = 1'b1; in_eop = 1'b1;
        #1;
        chk(!in_ready, "R11 second read stalls", {127'b0, in_ready}, 128'b0);
        @(negedge clk);
        #1;
        chk(!in_ready && cpl_data == exp_ur(16'h0A0A, 8'h5A), "R11 held completion", cpl_data, exp_ur(16'h0A0A, 8'h5A));
        cpl_ready = 1'b1;
        #1;
        chk(in_ready, "R11 slot frees", {127'b0, in_ready}, 128'b1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        #1;
        chk(cpl_valid && cpl_data == exp_ur(16'h0B0B, 8'h5B), "R11 second completion", cpl_data, exp_ur(16'h0B0B, 8'h5B));
        @(negedge clk);
        #1;
        chk(!cpl_valid, "R6 completion drained", {127'b0, cpl_valid}, 128'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule